// File: doc/BRIEF.md
# Zero-Column Index Parser

This block turns the per-group column index word of a bit-column compressed weight stream into a list of column descriptors for a bit-column-serial compute engine. Each index word is 8 bits. The top bit says whether the group carries a sign column. The seven lower bits mark which magnitude bit-columns are non-zero. When an index is accepted, the parser reports how many magnitude columns the group holds, so the engine can bound the group's latency. It raises a sign request for the whole group if the sign flag is set. It then hands out one shift amount per non-zero column, one per cycle, under a valid/ready handshake.

Columns come out from the most significant to the least significant. A priority encoder picks the highest pending bit, and that bit is cleared once its column has been handed off. A dense-mode input skips the presence bits and treats all seven magnitude columns as present. A new index is taken only after the last column of the current group has been handed off.

Top module: `zcol_idx_parser`

## Requirements
- R1: After a synchronous active-low reset, idx_ready is 1, and col_valid, sign_req, count_valid and group_done are 0.
- R2: An index is accepted in a cycle where idx_valid and idx_ready are both 1. idx_ready is 0 from the next cycle up to and including the group_done cycle, and it is 1 again in the cycle after group_done. idx_valid raised while the parser is busy has no effect on the column sequence.
- R3: Bit 7 of idx_word is the sign-column flag. When it is set at acceptance, sign_req is 1 from the cycle after acceptance through the group_done cycle. Otherwise sign_req stays 0.
- R4: count_valid is a one-cycle pulse in the cycle after acceptance. In that cycle col_count equals the number of set bits in idx_word[6:0], or 7 in dense mode. The sign bit is never counted.
- R5: The first column is offered in the cycle after acceptance. There is one column per handshake (col_valid and col_ready). col_shift gives the bit position (0 to 6) of each set magnitude bit, from highest to lowest.
- R6: col_last is 1 exactly on the final column of a group.
- R7: While col_valid is 1 and col_ready is 0, col_valid, col_shift and col_last hold their values into the next cycle.
- R8: An index with no magnitude bits set, outside dense mode, produces no col_valid. It reports col_count 0 and asserts group_done in the cycle after acceptance.
- R9: In dense mode (dense_mode 1 at acceptance), idx_word[6:0] is ignored and shifts 6, 5, 4, 3, 2, 1, 0 are emitted in that order.
- R10: group_done is a one-cycle pulse. It rises in the cycle where the last column is handed off, or in the cycle after acceptance for an empty group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_valid | input | 1 | Index word offered |
| idx_ready | output | 1 | Parser idle, can take an index |
| idx_word | input | 8 | Bit 7 sign-column flag, bits 6..0 magnitude column presence |
| dense_mode | input | 1 | Treat all magnitude columns as present |
| col_valid | output | 1 | Column descriptor offered |
| col_ready | input | 1 | Engine takes the column |
| col_shift | output | 3 | Bit significance of the offered column |
| col_last | output | 1 | Offered column is the group's final one |
| sign_req | output | 1 | Group carries a sign column |
| col_count | output | 3 | Non-zero magnitude column count, valid with count_valid |
| count_valid | output | 1 | col_count valid pulse |
| group_done | output | 1 | Group finished pulse |

## Verification
The sequence is tried with an empty index, with and without the sign flag, to tell a zero-column group from a broken done path. Single top-bit and bottom-bit indices expose off-by-one shift or count errors at both ends. A full mask and two alternating sparse masks check the descending order and the bit clearing. Dense mode is tried with a zero word and with a sparse word, to show that the presence bits are really ignored.

Output stalls check that the descriptor holds while col_ready is low. An index kept on the input during a busy group checks that it is not accepted early. A reset in mid-group checks the return to idle.

// File: rtl/zcip_pkg.sv
// Package: shared types for the zero-column index parser.
// Assumes nothing beyond a two-state group sequencer.
package zcip_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } zcip_state_e;
endpackage

// File: rtl/zcip_prio_enc.sv
// Highest-set-bit encoder over the pending column mask.
// Reports whether any bit is set, the position of the highest one,
// its one-hot mask, and whether it is the only bit left.
// Assumes W >= 2.
module zcip_prio_enc #(
    parameter int W  = 7,
    parameter int SW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [SW-1:0] pos,
    output logic [W-1:0]  onehot,
    output logic          single
);
    // Scan upward so that the highest set bit wins.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos   = SW'(i);
                found = 1'b1;
            end
        end
    end

    // One-hot image of the chosen bit.
    always_comb begin
        onehot = '0;
        if (found) onehot[pos] = 1'b1;
    end

    // Exactly one bit left means the chosen column is the last.
    always_comb begin
        single = found && ((vec & (vec - W'(1))) == '0);
    end
endmodule

// File: rtl/zcip_popcnt.sv
// Population count of the magnitude presence bits.
// Assumes CW is wide enough to hold W.
module zcip_popcnt #(
    parameter int W  = 7,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    // Add up the set bits.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/zcip_ctrl.sv
// Group sequencer: holds the pending column mask, the sign flag and
// the column count, and moves between idle and busy.
// Assumes col_fire is raised only while busy with a column pending.
module zcip_ctrl
    import zcip_pkg::*;
#(
    parameter int MAG_W = 7,
    parameter int CW    = $clog2(MAG_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_fire,
    input  logic [MAG_W-1:0] mag_load,
    input  logic             sign_load,
    input  logic [CW-1:0]    count_load,
    input  logic             col_fire,
    input  logic [MAG_W-1:0] col_onehot,
    input  logic             pend_any,
    input  logic             pend_single,
    output logic             busy,
    output logic [MAG_W-1:0] pending_q,
    output logic             sign_q,
    output logic [CW-1:0]    count_q,
    output logic             first_q,
    output logic             done
);
    zcip_state_e state_q;

    // The group ends when no column is pending or the last one is handed off.
    always_comb begin
        done = (state_q == ST_BUSY) && (!pend_any || (col_fire && pend_single));
        busy = (state_q == ST_BUSY);
    end

    // State, mask, sign and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            sign_q    <= 1'b0;
            count_q   <= '0;
            first_q   <= 1'b0;
        end else begin
            first_q <= idx_fire;
            if (state_q == ST_IDLE) begin
                if (idx_fire) begin
                    state_q   <= ST_BUSY;
                    pending_q <= mag_load;
                    sign_q    <= sign_load;
                    count_q   <= count_load;
                end
            end else begin
                if (col_fire) pending_q <= pending_q & ~col_onehot;
                if (done) begin
                    state_q <= ST_IDLE;
                    sign_q  <= 1'b0;
                end
            end
        end
    end

    // R5
    handoff_clears_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_fire |=> ($countones(pending_q) == $countones($past(pending_q)) - 1));

    // R2
    no_accept_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !idx_fire);

    // R3
    sign_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sign_q |-> busy);
endmodule

// File: rtl/zcol_idx_parser.sv
// Zero-column index parser: accepts one 8-bit index per group (MSB is
// the sign-column flag, the rest mark non-zero magnitude columns) and
// emits one shift amount per non-zero column, highest first.
// Assumes the consumer holds col_ready steady within a cycle.
module zcol_idx_parser #(
    parameter int IDX_W   = 8,
    parameter int MAG_W   = IDX_W - 1,
    parameter int SHIFT_W = (MAG_W > 1) ? $clog2(MAG_W) : 1,
    parameter int CNT_W   = $clog2(MAG_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_valid,
    output logic               idx_ready,
    input  logic [IDX_W-1:0]   idx_word,
    input  logic               dense_mode,
    output logic               col_valid,
    input  logic               col_ready,
    output logic [SHIFT_W-1:0] col_shift,
    output logic               col_last,
    output logic               sign_req,
    output logic [CNT_W-1:0]   col_count,
    output logic               count_valid,
    output logic               group_done
);
    logic               busy;
    logic               idx_fire;
    logic               col_fire;
    logic [MAG_W-1:0]   mag_sel;
    logic [CNT_W-1:0]   mag_cnt;
    logic [MAG_W-1:0]   pending_q;
    logic [MAG_W-1:0]   col_onehot;
    logic               pend_any;
    logic               pend_single;
    logic               sign_q;
    logic [CNT_W-1:0]   count_q;
    logic               first_q;
    logic               done;

    // Select the presence mask: dense mode marks every magnitude column.
    always_comb begin
        mag_sel = dense_mode ? {MAG_W{1'b1}} : idx_word[MAG_W-1:0];
    end

    // Handshakes on both sides.
    always_comb begin
        idx_ready = !busy;
        idx_fire  = idx_valid && idx_ready;
        col_valid = busy && pend_any;
        col_fire  = col_valid && col_ready;
    end

    zcip_popcnt #(.W(MAG_W), .CW(CNT_W)) i_popcnt (
        .vec (mag_sel),
        .cnt (mag_cnt)
    );

    zcip_prio_enc #(.W(MAG_W), .SW(SHIFT_W)) i_prio (
        .vec    (pending_q),
        .found  (pend_any),
        .pos    (col_shift),
        .onehot (col_onehot),
        .single (pend_single)
    );

    zcip_ctrl #(.MAG_W(MAG_W), .CW(CNT_W)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx_fire    (idx_fire),
        .mag_load    (mag_sel),
        .sign_load   (idx_word[IDX_W-1]),
        .count_load  (mag_cnt),
        .col_fire    (col_fire),
        .col_onehot  (col_onehot),
        .pend_any    (pend_any),
        .pend_single (pend_single),
        .busy        (busy),
        .pending_q   (pending_q),
        .sign_q      (sign_q),
        .count_q     (count_q),
        .first_q     (first_q),
        .done        (done)
    );

    // Drive the group-level outputs.
    always_comb begin
        col_last    = col_valid && pend_single;
        sign_req    = sign_q;
        col_count   = count_q;
        count_valid = first_q;
        group_done  = done;
    end

    // R4
    count_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_fire |=> count_valid);

    // R5
    first_col_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_fire && (mag_sel != '0)) |=> col_valid);

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !col_ready) |=> (col_valid && $stable(col_shift) && $stable(col_last)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        group_done |=> !group_done);

    // R8
    empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_fire && (mag_sel == '0)) |=> (group_done && !col_valid));
endmodule

// File: tb/test_zcol_idx_parser.sv
module test_zcol_idx_parser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idx_valid = 1'b0;
    logic       idx_ready;
    logic [7:0] idx_word = '0;
    logic       dense_mode = 1'b0;
    logic       col_valid;
    logic       col_ready = 1'b1;
    logic [2:0] col_shift;
    logic       col_last;
    logic       sign_req;
    logic [2:0] col_count;
    logic       count_valid;
    logic       group_done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    zcol_idx_parser i_zcol_idx_parser (
        .clk(clk), .rst_n(rst_n), .idx_valid(idx_valid), .idx_ready(idx_ready),
        .idx_word(idx_word), .dense_mode(dense_mode), .col_valid(col_valid),
        .col_ready(col_ready), .col_shift(col_shift), .col_last(col_last),
        .sign_req(sign_req), .col_count(col_count), .count_valid(count_valid),
        .group_done(group_done)
    );

    typedef struct packed {
        logic       dense;
        logic [7:0] idx;
        logic [2:0] cnt;
        logic       sign;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 3'd0, 1'b0},
        '{1'b0, 8'h80, 3'd0, 1'b1},
        '{1'b0, 8'h01, 3'd1, 1'b0},
        '{1'b0, 8'h40, 3'd1, 1'b0},
        '{1'b0, 8'h7F, 3'd7, 1'b0},
        '{1'b0, 8'hA5, 3'd3, 1'b1},
        '{1'b0, 8'h2A, 3'd3, 1'b0},
        '{1'b1, 8'h00, 3'd7, 1'b0},
        '{1'b1, 8'h83, 3'd7, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Run one group: all driving and sampling at the falling edge.
    task automatic run_group(input vec_t v, input bit stall, input bit poke);
        logic [6:0] mask;
        int npos;
        int seen;
        mask = v.dense ? 7'h7F : v.idx[6:0];
        npos = 0;
        for (int p = 6; p >= 0; p--) if (mask[p]) npos++;
        @(negedge clk);
        chk(idx_ready == 1'b1, "R2 ready idle", idx_ready, 1);
        idx_valid  = 1'b1;
        idx_word   = v.idx;
        dense_mode = v.dense;
        @(negedge clk);
        if (poke) begin
            idx_word = 8'hFF; dense_mode = 1'b1;
        end else begin
            idx_valid = 1'b0; idx_word = '0; dense_mode = 1'b0;
        end
        #0.1;
        chk(count_valid == 1'b1, "R4 count_valid", count_valid, 1);
        chk(col_count == v.cnt, "R4 col_count", col_count, v.cnt);
        chk(sign_req == v.sign, "R3 sign_req", sign_req, v.sign);
        chk(idx_ready == 1'b0, "R2 busy", idx_ready, 0);
        if (npos == 0) begin
            chk(col_valid == 1'b0, "R8 no column", col_valid, 0);
            chk(group_done == 1'b1, "R8 done", group_done, 1);
        end
        seen = 0;
        for (int p = 6; p >= 0; p--) begin
            if (mask[p]) begin
                seen++;
                if (stall && seen == 1) begin
                    col_ready = 1'b0;
                    #0.1;
                    chk(col_valid == 1'b1, "R7 valid before stall", col_valid, 1);
                    @(negedge clk);
                    chk(col_valid == 1'b1, "R7 valid held", col_valid, 1);
                    chk(col_shift == 3'(p), "R7 shift held", col_shift, p);
                    chk(count_valid == 1'b0, "R4 pulse once", count_valid, 0);
                    col_ready = 1'b1;
                end
                #0.1;
                chk(col_valid == 1'b1, "R5 col_valid", col_valid, 1);
                chk(col_shift == 3'(p), v.dense ? "R9 dense shift" : "R5 shift order", col_shift, p);
                chk(col_last == (seen == npos), "R6 col_last", col_last, (seen == npos));
                chk(group_done == (seen == npos), "R10 group_done", group_done, (seen == npos));
                chk(sign_req == v.sign, "R3 sign held", sign_req, v.sign);
                if (poke) chk(idx_ready == 1'b0, "R2 no early accept", idx_ready, 0);
                if (seen == npos) begin
                    idx_valid = 1'b0; idx_word = '0; dense_mode = 1'b0;
                end
                @(negedge clk);
            end
        end
        if (npos == 0) @(negedge clk);
        #0.1;
        chk(idx_ready == 1'b1, "R2 ready after done", idx_ready, 1);
        chk(sign_req == 1'b0, "R3 sign cleared", sign_req, 0);
        chk(col_valid == 1'b0, "R5 idle no column", col_valid, 0);
        chk(group_done == 1'b0, "R10 done pulse", group_done, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.1;
        chk(idx_ready == 1'b1, "R1 ready", idx_ready, 1);
        chk(col_valid == 1'b0, "R1 col_valid", col_valid, 0);
        chk(sign_req == 1'b0, "R1 sign_req", sign_req, 0);
        chk(count_valid == 1'b0, "R1 count_valid", count_valid, 0);
        chk(group_done == 1'b0, "R1 group_done", group_done, 0);

        for (int k = 0; k < NV; k++) run_group(VEC[k], k[0], 1'b0);

        // R2: index held on the input while busy is not taken early
        run_group('{1'b0, 8'h92, 3'd2, 1'b1}, 1'b0, 1'b1);
        // R9: dense with every presence bit clear and sign flag set
        run_group('{1'b1, 8'h80, 3'd7, 1'b1}, 1'b1, 1'b0);

        // R1: reset in mid-group returns to idle
        @(negedge clk);
        idx_valid = 1'b1; idx_word = 8'hFF;
        @(negedge clk);
        idx_valid = 1'b0; idx_word = '0;
        col_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; col_ready = 1'b1;
        #0.1;
        chk(idx_ready == 1'b1, "R1 ready after reset", idx_ready, 1);
        chk(col_valid == 1'b0, "R1 no column after reset", col_valid, 0);
        chk(sign_req == 1'b0, "R1 sign after reset", sign_req, 0);

        run_group('{1'b0, 8'h08, 3'd1, 1'b0}, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule